// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

The block links two parallel buses, A and B, in both directions. Each direction has its own holding register, loaded when that direction's capture strobe rises. Each direction also has a source select that picks what reaches the far bus: the live value on the near bus, or the value held in the register. Each bus appears as three signals: a data input, a data output and an output enable. A tri-state bus or a testbench resolves them.

Everything runs on one system clock. A capture strobe counts as rising when one sample sees it low and the next sees it high. Registers load on that edge, whatever the selects and enables are doing. Data outputs and output enables are registered, so a change on any input reaches the ports one clock later without glitches.

When both sides drive with live selects, each side sends back what it receives. Once the outside drivers let go, a bus wired back to itself through the block keeps its last value, and the holding registers take no part in this.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both output enables, both data outputs and both holding registers are zero. Zero is therefore what the stored selects show before any capture. Assertion of `rst_n` takes effect without waiting for a clock.
- R2: When `stb_ab` is sampled 1 after being sampled 0 on the previous clock, the A-side register loads `a_in`.
- R3: When `stb_ba` is sampled 1 after being sampled 0 on the previous clock, the B-side register loads `b_in`.
- R4: Capture ignores `sel_ab`, `sel_ba`, `dir_b` and `oe_a_n`. Both registers can load on the same clock while both output enables are 0.
- R5: A strobe held at 1 for more clocks leaves its register unchanged.
- R6: `sel_ab` = 0 sends the live `a_in` to `b_out` one clock later. `sel_ba` = 0 sends the live `b_in` to `a_out` one clock later.
- R7: `sel_ab` = 1 sends the A-side register to `b_out`. `sel_ba` = 1 sends the B-side register to `a_out`. Both take effect one clock later.
- R8: `b_oe` follows `dir_b` and `a_oe` follows the inverse of `oe_a_n`, each one clock later. With `dir_b` = 0 and `oe_a_n` = 1, both enables are 0.
- R9: Neither path inverts any bit.
- R10: Both enables are 1, both selects are 0, and each bus reads back its own driven value. In that state, after the outside drivers release, both buses keep their last value for at least 10 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts at once, releases in step with the clock |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| stb_ab | input | 1 | Capture strobe for the A-side register |
| stb_ba | input | 1 | Capture strobe for the B-side register |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B |
| dir_b | input | 1 | 1 requests driving bus B |
| oe_a_n | input | 1 | 0 requests driving bus A |

## Verification
A register that loaded on the wrong strobe sample, or missed a load, stays hidden while the live select is chosen. It appears on the far bus one clock after the stored select is raised. Stray reloads from a held strobe appear as a change in the stored output with no new rising edge. A broken strobe edge detector, or an enable wired to the wrong control, shows as a wrong port value one clock after the stimulus. In the bus-hold loop, any inversion or a missing enable makes the held value drift within two clocks of the drivers releasing.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_sel_e;
  localparam int NDIR = 2;   // index 0: A toward B, index 1: B toward A
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] store_q
);
  logic         stb_q;
  logic         cap_en;
  logic [W-1:0] store_d;

  always_comb begin
    cap_en  = stb & ~stb_q;
    store_d = cap_en ? din : store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      store_q <= '0;
    end else begin
      stb_q   <= stb;
      store_q <= store_d;
    end
  end
endmodule

// File: rtl/xcvr_drv.sv
module xcvr_drv
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         en_req,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic [W-1:0] dout_d;

  always_comb begin
    if (src_sel_e'(sel) == SRC_STORED) dout_d = stored;
    else                               dout_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      dout <= dout_d;
      oe   <= en_req;
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         dir_b,
  input  logic         oe_a_n
);
  logic                      rst_q;
  logic [NDIR-1:0][W-1:0]    near_in;
  logic [NDIR-1:0][W-1:0]    store_q;
  logic [NDIR-1:0][W-1:0]    far_out;
  logic [NDIR-1:0]           stb_v;
  logic [NDIR-1:0]           sel_v;
  logic [NDIR-1:0]           en_v;
  logic [NDIR-1:0]           oe_v;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  always_comb begin
    near_in = {b_in, a_in};
    stb_v   = {stb_ba, stb_ab};
    sel_v   = {sel_ba, sel_ab};
    en_v    = {~oe_a_n, dir_b};
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    xcvr_cap_reg #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_q), .stb(stb_v[g]),
      .din(near_in[g]), .store_q(store_q[g])
    );
    xcvr_drv #(.W(W)) u_drv (
      .clk(clk), .rst_n(rst_q), .sel(sel_v[g]),
      .live(near_in[g]), .stored(store_q[g]),
      .en_req(en_v[g]), .dout(far_out[g]), .oe(oe_v[g])
    );
  end

  assign b_out = far_out[0];
  assign b_oe  = oe_v[0];
  assign a_out = far_out[1];
  assign a_oe  = oe_v[1];
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_q,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic         stb_ab,
  input logic         stb_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         dir_b,
  input logic         oe_a_n,
  input logic [W-1:0] st_ab,
  input logic [W-1:0] st_ba
);
  logic live_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  a_r2_cap_a: assert property (@(posedge clk) disable iff (!rst_q)
    (live_q && stb_ab && !$past(stb_ab)) |=> st_ab == $past(a_in));

  a_r3_cap_b: assert property (@(posedge clk) disable iff (!rst_q)
    (live_q && stb_ba && !$past(stb_ba)) |=> st_ba == $past(b_in));

  a_r5_held_ab: assert property (@(posedge clk) disable iff (!rst_q)
    (live_q && stb_ab && $past(stb_ab)) |=> $stable(st_ab));

  a_r5_held_ba: assert property (@(posedge clk) disable iff (!rst_q)
    (live_q && stb_ba && $past(stb_ba)) |=> $stable(st_ba));

  a_r6_live_b: assert property (@(posedge clk) disable iff (!rst_q)
    (rst_q && !sel_ab) |=> b_out == $past(a_in));

  a_r6_live_a: assert property (@(posedge clk) disable iff (!rst_q)
    (rst_q && !sel_ba) |=> a_out == $past(b_in));

  a_r7_stored_b: assert property (@(posedge clk) disable iff (!rst_q)
    (rst_q && sel_ab) |=> b_out == $past(st_ab));

  a_r8_b_enable: assert property (@(posedge clk) disable iff (!rst_q)
    rst_q |=> b_oe == $past(dir_b));

  a_r8_a_enable: assert property (@(posedge clk) disable iff (!rst_q)
    rst_q |=> a_oe == !$past(oe_a_n));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q(rst_q),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe), .stb_ab(stb_ab), .stb_ba(stb_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .dir_b(dir_b), .oe_a_n(oe_a_n),
  .st_ab(store_q[0]), .st_ba(store_q[1])
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 7;

  typedef struct packed {
    logic stb_ab, stb_ba, sel_ab, sel_ba, dir_b, oe_a_n;
    logic [7:0] a, b;
    logic xa_oe, xb_oe;
    logic [7:0] xa, xb;
  } vec_t;

  // each vector is held two clocks, then outputs are compared
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h11,8'h22, 1'b0,1'b0, 8'h22,8'h11},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 8'h33,8'h44, 1'b1,1'b1, 8'h00,8'h33},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 8'h55,8'h66, 1'b0,1'b1, 8'h66,8'h33},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h77,8'h88, 1'b1,1'b0, 8'h66,8'h77},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 8'h9A,8'hBC, 1'b0,1'b0, 8'hBC,8'h9A},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'hC3,8'h3C, 1'b1,1'b1, 8'h3C,8'hC3},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 8'hFF,8'h00, 1'b1,1'b1, 8'hBC,8'h9A}
  };
  localparam string VTAG [NV] = '{"R6 R8", "R2 R7 R8", "R3 R5",
                                  "R6 R7", "R4", "R9 R6", "R7 R4"};

  logic clk = 1'b0;
  logic rst_n;
  logic stb_ab, stb_ba, sel_ab, sel_ba, dir_b, oe_a_n;
  logic ext_a_en, ext_b_en;
  logic [W-1:0] ext_a, ext_b;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  wire  [W-1:0] a_bus = ext_a_en ? ext_a : (a_oe ? a_out : 'z);
  wire  [W-1:0] b_bus = ext_b_en ? ext_b : (b_oe ? b_out : 'z);
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe),
    .stb_ab(stb_ab), .stb_ba(stb_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .dir_b(dir_b), .oe_a_n(oe_a_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic sa, input logic sb, input logic d, input logic on);
    sel_ab = sa; sel_ba = sb; dir_b = d; oe_a_n = on;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    stb_ab = 1'b0; stb_ba = 1'b0;
    ctl(1'b0, 1'b0, 1'b0, 1'b1);
    ext_a_en = 1'b1; ext_b_en = 1'b1; ext_a = 8'hA5; ext_b = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: everything quiet during reset
    check("R1 a_oe", a_oe, 0);  check("R1 b_oe", b_oe, 0);
    check("R1 a_out", a_out, 0); check("R1 b_out", b_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: stored selects show zero before any capture
    ctl(1'b1, 1'b1, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check("R1 stored a_out", a_out, 0); check("R1 stored b_out", b_out, 0);

    for (int i = 0; i < NV; i++) begin
      stb_ab = VEC[i].stb_ab; stb_ba = VEC[i].stb_ba;
      ctl(VEC[i].sel_ab, VEC[i].sel_ba, VEC[i].dir_b, VEC[i].oe_a_n);
      ext_a = VEC[i].a; ext_b = VEC[i].b;
      repeat (2) @(negedge clk);
      check({VTAG[i], " a_oe"}, a_oe, VEC[i].xa_oe);
      check({VTAG[i], " b_oe"}, b_oe, VEC[i].xb_oe);
      check({VTAG[i], " a_out"}, a_out, VEC[i].xa);
      check({VTAG[i], " b_out"}, b_out, VEC[i].xb);
    end

    // R8: enable changes land exactly one clock later
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    #1;
    check("R8 b_oe before edge", b_oe, 1); check("R8 a_oe before edge", a_oe, 1);
    @(negedge clk);
    check("R8 b_oe after edge", b_oe, 0); check("R8 a_oe after edge", a_oe, 0);

    // R10: bus hold through the loop-back
    ctl(1'b0, 1'b0, 1'b1, 1'b0);
    ext_a = 8'h5A; ext_b_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 b bus follows a", b_bus, 8'h5A);
    ext_a_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R10 a bus held", a_bus, 8'h5A);
      check("R10 b bus held", b_bus, 8'h5A);
    end

    // R1: reset takes effect without a clock edge
    ext_a_en = 1'b1; ext_b_en = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 async a_oe", a_oe, 0); check("R1 async b_out", b_out, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule